// File: doc/BRIEF.md
# Processor Reset and Strap Sequencer

This block decides how a bus agent comes out of reset. A raw active-low reset is brought into the bus clock domain through two flip-flops. While the synchronised reset is active, every bus output is forced inactive and both cache levels are told to invalidate, discarding their contents without any write-back. The agent's configuration straps and its active-low init request are sampled in the single cycle where the synchronised reset goes from active to inactive, and never at any other time.

At that release point the captured straps pick the next step. A strap bit can park the agent, which keeps its bus outputs tri-stated and never starts fetching. Otherwise, an asserted init request starts a modelled self-test. The self-test is a fixed-length counter that records whether a fault input was seen and reports the result through a pass flag and a one-cycle done pulse. Execution then starts with a one-cycle fetch strobe that carries the reset vector. A separate monitor counts how long the synchronised reset was held and flags a release that came before a minimum time, which is derived from a clock-frequency parameter.

Top module: `rst_strap_seq`

## Requirements
- R1: From the second rising clock edge that samples `rst_n` low, and for as long as reset stays held, `bus_oe` is 0 and `bus_out` is all zeros.
- R2: `cache_inv` is 2'b11 (bit 0 for the first level, bit 1 for the second) while the synchronised reset is active, and 2'b00 otherwise.
- R3: `strap_q` takes the value of `strap_in` in the release cycle. The release cycle is the first cycle in which the twice-registered reset reads inactive. Later changes of `strap_in` leave `strap_q` unchanged until the next release.
- R4: If `init_n` is 0 in the release cycle and strap bit PARK_BIT is 0, `selftest_busy` is high for exactly SELFTEST_CYC consecutive cycles, followed by exactly one cycle of `selftest_done`. In any other case neither signal rises.
- R5: Unless the agent is parked, `fetch_go` pulses for exactly one cycle per release, with `fetch_addr` equal to RST_VEC (default 36'hF_FFFF_FFF0) during that cycle. When the self-test runs, `fetch_go` comes exactly one cycle after `selftest_done`.
- R6: `selftest_pass` is 1 after a self-test in which `selftest_fault` was never high during a busy cycle. It is 0 after a self-test that saw a fault, and 0 when no self-test ran.
- R7: If strap bit PARK_BIT is 1 in the release cycle, the agent is parked: `bus_oe` stays 0, no self-test starts (even with `init_n` low), and `fetch_go` never rises.
- R8: After `fetch_go` in a non-parked boot, `bus_oe` is 1 and `bus_out` equals `core_bus` until the next reset.
- R9: `hold_short` pulses once after a release if the synchronised reset was active for fewer than CLK_KHZ*HOLD_MS cycles. A hold of exactly that many cycles or more does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Raw active-low reset, asynchronous to nothing but unsynchronised |
| init_n | input | 1 | Active-low self-test request, sampled at release |
| strap_in | input | STRAP_W | Configuration straps, sampled at release |
| core_bus | input | OUT_W | Bus values the agent would drive when enabled |
| selftest_fault | input | 1 | Fault indication observed during the self-test |
| bus_out | output | OUT_W | Bus drive values, zero when disabled |
| bus_oe | output | 1 | Bus output enable, 0 means tri-stated |
| cache_inv | output | 2 | Invalidate-without-write-back request per cache level |
| strap_q | output | STRAP_W | Straps captured at the last release |
| selftest_busy | output | 1 | Self-test counter running |
| selftest_done | output | 1 | One-cycle end-of-self-test pulse |
| selftest_pass | output | 1 | Self-test result |
| fetch_go | output | 1 | One-cycle start-of-execution strobe |
| fetch_addr | output | ADDR_W | Reset vector, valid from fetch_go until next reset |
| hold_short | output | 1 | One-cycle pulse for a release before the minimum hold |

## Verification
The bench builds the block with CLK_KHZ=20 and HOLD_MS=1, which gives a minimum hold of 20 cycles. At that setting both sides of the early-release threshold (19 and 20 held cycles) fit into a few hundred clock cycles, where the default would need a hundred thousand cycles per reset. SELFTEST_CYC stays at its default of 64, so the done pulse and the fetch strobe after it are exercised at their real spacing. OUT_W is narrowed to 16, which keeps the mirrored bus compact without changing any sequencing.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    typedef enum logic [2:0] {
        SEQ_HOLD     = 3'd0,
        SEQ_SELFTEST = 3'd1,
        SEQ_LAUNCH   = 3'd2,
        SEQ_RUN      = 3'd3,
        SEQ_PARK     = 3'd4
    } seq_state_e;

    // Minimum reset hold in clock cycles for a frequency in kHz and a time in ms.
    function automatic int unsigned hold_cycles(input int unsigned khz, input int unsigned ms);
        return khz * ms;
    endfunction

endpackage

// File: rtl/rst_sync2.sv
module rst_sync2 (
    input  logic clk,
    input  logic rst_n_raw,
    output logic rst_act
);

    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.s1 = rst_n_raw;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk) begin
        sync_q <= sync_d;
    end

    assign rst_act = ~sync_q.s2;

endmodule

// File: rtl/rst_hold_mon.sv
module rst_hold_mon #(
    parameter int unsigned HOLD_CYC = 100000
) (
    input  logic clk,
    input  logic rst_act,
    input  logic release_ev,
    output logic hold_short
);

    localparam int unsigned CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] HOLD_LIM = CW'(HOLD_CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          flag;
    } mon_t;

    mon_t mon_d, mon_q;

    always_comb begin
        mon_d = mon_q;
        if (rst_act) begin
            mon_d.cnt = (mon_q.cnt == HOLD_LIM) ? mon_q.cnt : mon_q.cnt + 1'b1;
        end else begin
            mon_d.cnt = '0;
        end
        mon_d.flag = release_ev && (mon_q.cnt < HOLD_LIM);
    end

    always_ff @(posedge clk) begin
        mon_q <= mon_d;
    end

    assign hold_short = mon_q.flag;

endmodule

// File: rtl/rst_selftest.sv
module rst_selftest #(
    parameter int unsigned RUN_CYC = 64
) (
    input  logic clk,
    input  logic abort,
    input  logic start,
    input  logic fault,
    output logic busy,
    output logic done,
    output logic pass
);

    localparam int unsigned CW = (RUN_CYC > 2) ? $clog2(RUN_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(RUN_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          busy;
        logic          fail;
        logic          done;
        logic          pass;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (abort) begin
            st_d = '0;
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
            st_d.fail = 1'b0;
            st_d.pass = 1'b0;
        end else if (st_q.busy) begin
            st_d.fail = st_q.fail | fault;
            if (st_q.cnt == LAST) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.pass = ~(st_q.fail | fault);
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign busy = st_q.busy;
    assign done = st_q.done;
    assign pass = st_q.pass;

endmodule

// File: rtl/rst_strap_seq.sv
module rst_strap_seq #(
    parameter int unsigned STRAP_W      = 8,
    parameter int unsigned OUT_W        = 32,
    parameter int unsigned ADDR_W       = 36,
    parameter int unsigned CLK_KHZ      = 100000,
    parameter int unsigned HOLD_MS      = 1,
    parameter int unsigned SELFTEST_CYC = 64,
    parameter int unsigned PARK_BIT     = 0,
    parameter logic [ADDR_W-1:0] RST_VEC = 36'hF_FFFF_FFF0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               init_n,
    input  logic [STRAP_W-1:0] strap_in,
    input  logic [OUT_W-1:0]   core_bus,
    input  logic               selftest_fault,
    output logic [OUT_W-1:0]   bus_out,
    output logic               bus_oe,
    output logic [1:0]         cache_inv,
    output logic [STRAP_W-1:0] strap_q,
    output logic               selftest_busy,
    output logic               selftest_done,
    output logic               selftest_pass,
    output logic               fetch_go,
    output logic [ADDR_W-1:0]  fetch_addr,
    output logic               hold_short
);

    import rst_seq_pkg::*;

    localparam int unsigned HOLD_CYC = hold_cycles(CLK_KHZ, HOLD_MS);

    typedef struct packed {
        seq_state_e         state;
        logic               act_prev;
        logic [STRAP_W-1:0] straps;
    } seq_t;

    seq_t seq_d, seq_q;

    logic rst_act;
    logic rel;
    logic st_start;
    logic st_done;

    rst_sync2 sync_i (
        .clk      (clk),
        .rst_n_raw(rst_n),
        .rst_act  (rst_act)
    );

    rst_hold_mon #(.HOLD_CYC(HOLD_CYC)) hold_i (
        .clk       (clk),
        .rst_act   (rst_act),
        .release_ev(rel),
        .hold_short(hold_short)
    );

    rst_selftest #(.RUN_CYC(SELFTEST_CYC)) st_i (
        .clk  (clk),
        .abort(rst_act),
        .start(st_start),
        .fault(selftest_fault),
        .busy (selftest_busy),
        .done (st_done),
        .pass (selftest_pass)
    );

    assign rel = seq_q.act_prev & ~rst_act;

    always_comb begin
        seq_d          = seq_q;
        seq_d.act_prev = rst_act;
        st_start       = 1'b0;
        if (rst_act) begin
            seq_d.state = SEQ_HOLD;
        end else begin
            unique case (seq_q.state)
                SEQ_HOLD: begin
                    if (rel) begin
                        seq_d.straps = strap_in;
                        if (strap_in[PARK_BIT]) begin
                            seq_d.state = SEQ_PARK;
                        end else if (!init_n) begin
                            seq_d.state = SEQ_SELFTEST;
                            st_start    = 1'b1;
                        end else begin
                            seq_d.state = SEQ_LAUNCH;
                        end
                    end
                end
                SEQ_SELFTEST: begin
                    if (st_done) seq_d.state = SEQ_LAUNCH;
                end
                SEQ_LAUNCH: seq_d.state = SEQ_RUN;
                SEQ_RUN:    seq_d.state = SEQ_RUN;
                SEQ_PARK:   seq_d.state = SEQ_PARK;
                default:    seq_d.state = SEQ_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        seq_q <= seq_d;
    end

    assign selftest_done = st_done;
    assign bus_oe        = (seq_q.state == SEQ_RUN) && !rst_act;
    assign bus_out       = bus_oe ? core_bus : '0;
    assign cache_inv     = {2{rst_act}};
    assign strap_q       = seq_q.straps;
    assign fetch_go      = (seq_q.state == SEQ_LAUNCH) && !rst_act;
    assign fetch_addr    = (!rst_act && (seq_q.state == SEQ_LAUNCH || seq_q.state == SEQ_RUN))
                           ? RST_VEC : '0;

endmodule

// File: rtl/rst_strap_seq_chk.sv
module rst_strap_seq_chk #(
    parameter int unsigned STRAP_W  = 8,
    parameter int unsigned OUT_W    = 32,
    parameter int unsigned ADDR_W   = 36,
    parameter int unsigned PARK_BIT = 0,
    parameter logic [ADDR_W-1:0] RST_VEC = 36'hF_FFFF_FFF0
) (
    input logic               clk,
    input logic               rst_act,
    input logic               rel,
    input logic               bus_oe,
    input logic [OUT_W-1:0]   bus_out,
    input logic [1:0]         cache_inv,
    input logic [STRAP_W-1:0] strap_q,
    input logic               selftest_busy,
    input logic               selftest_done,
    input logic               fetch_go,
    input logic [ADDR_W-1:0]  fetch_addr
);

    logic [2:0] warm_q = 3'd0;
    logic       armed;

    always_ff @(posedge clk) begin
        if (warm_q != 3'd6) warm_q <= warm_q + 3'd1;
    end

    assign armed = (warm_q == 3'd6);

    // R1
    out_quiet_chk: assert property (@(posedge clk) disable iff (!armed)
        rst_act |-> (!bus_oe && bus_out == '0));

    // R2
    inv_both_chk: assert property (@(posedge clk) disable iff (!armed)
        rst_act |-> (cache_inv == 2'b11));

    // R3
    strap_hold_chk: assert property (@(posedge clk) disable iff (!armed)
        !rel |=> $stable(strap_q));

    // R4
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!armed)
        selftest_busy |-> !bus_oe && !fetch_go);

    // R5
    go_after_done_chk: assert property (@(posedge clk) disable iff (!armed)
        (selftest_done && !rst_act) |=> (fetch_go || rst_act));

    // R5
    go_single_chk: assert property (@(posedge clk) disable iff (!armed)
        fetch_go |=> !fetch_go);

    // R5
    go_vec_chk: assert property (@(posedge clk) disable iff (!armed)
        fetch_go |-> (fetch_addr == RST_VEC));

    // R7
    park_quiet_chk: assert property (@(posedge clk) disable iff (!armed)
        (!rst_act && strap_q[PARK_BIT] && !$past(rel)) |-> (!bus_oe && !fetch_go && !selftest_busy));

endmodule

bind rst_strap_seq rst_strap_seq_chk #(
    .STRAP_W (STRAP_W),
    .OUT_W   (OUT_W),
    .ADDR_W  (ADDR_W),
    .PARK_BIT(PARK_BIT),
    .RST_VEC (RST_VEC)
) chk_i (
    .clk          (clk),
    .rst_act      (rst_act),
    .rel          (rel),
    .bus_oe       (bus_oe),
    .bus_out      (bus_out),
    .cache_inv    (cache_inv),
    .strap_q      (strap_q),
    .selftest_busy(selftest_busy),
    .selftest_done(selftest_done),
    .fetch_go     (fetch_go),
    .fetch_addr   (fetch_addr)
);

// File: tb/rst_strap_seq_tb_top.sv
module rst_strap_seq_tb_top;

    localparam int unsigned SW   = 8;
    localparam int unsigned OW   = 16;
    localparam int unsigned AW   = 36;
    localparam int unsigned KHZ  = 20;
    localparam int unsigned HMS  = 1;
    localparam int unsigned HOLD = KHZ * HMS;
    localparam int unsigned STC  = 64;
    localparam logic [AW-1:0] VEC = 36'hF_FFFF_FFF0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          init_n = 1'b1;
    logic [SW-1:0] strap_in = '0;
    logic [OW-1:0] core_bus = '0;
    logic          selftest_fault = 1'b0;
    logic [OW-1:0] bus_out;
    logic          bus_oe;
    logic [1:0]    cache_inv;
    logic [SW-1:0] strap_q;
    logic          selftest_busy, selftest_done, selftest_pass;
    logic          fetch_go;
    logic [AW-1:0] fetch_addr;
    logic          hold_short;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    rst_strap_seq #(
        .STRAP_W(SW), .OUT_W(OW), .ADDR_W(AW), .CLK_KHZ(KHZ), .HOLD_MS(HMS),
        .SELFTEST_CYC(STC), .PARK_BIT(0), .RST_VEC(VEC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .init_n(init_n), .strap_in(strap_in),
        .core_bus(core_bus), .selftest_fault(selftest_fault),
        .bus_out(bus_out), .bus_oe(bus_oe), .cache_inv(cache_inv), .strap_q(strap_q),
        .selftest_busy(selftest_busy), .selftest_done(selftest_done),
        .selftest_pass(selftest_pass), .fetch_go(fetch_go), .fetch_addr(fetch_addr),
        .hold_short(hold_short)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit exp_park(input logic [SW-1:0] s);
        return s[0];
    endfunction

    function automatic bit exp_bist(input logic [SW-1:0] s, input bit init_v);
        return !s[0] && !init_v;
    endfunction

    task automatic run_boot(input int n_low, input logic [SW-1:0] s,
                            input bit init_v, input bit fault_v);
        int busy_cyc = 0;
        int done_cnt = 0;
        int go_cnt = 0;
        int short_cnt = 0;
        int t_done = -1;
        int t_go = -1;
        logic [AW-1:0] addr_at_go = '0;
        bit mirror_bad = 1'b0;
        bit park = exp_park(s);
        bit bist = exp_bist(s, init_v);
        @(negedge clk);
        rst_n    = 1'b0;
        strap_in = SW'($urandom);
        init_n   = 1'($urandom);
        core_bus = OW'($urandom);
        repeat (3) @(negedge clk);
        check("R1", "bus_oe in reset", 64'(bus_oe), 64'd0);
        check("R1", "bus_out in reset", 64'(bus_out), 64'd0);
        check("R2", "cache_inv in reset", 64'(cache_inv), 64'd3);
        repeat (n_low - 4) @(negedge clk);
        @(negedge clk);
        strap_in = s;
        init_n   = init_v;
        rst_n    = 1'b1;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (k == 4) begin
                strap_in = ~s;
                init_n   = ~init_v;
            end
            selftest_fault = fault_v && (k == 30);
            if (selftest_busy) busy_cyc++;
            if (selftest_done) begin done_cnt++; t_done = k; end
            if (fetch_go) begin go_cnt++; t_go = k; addr_at_go = fetch_addr; end
            if (hold_short) short_cnt++;
            if (bus_oe && bus_out !== core_bus) mirror_bad = 1'b1;
            if (!bus_oe && bus_out !== '0) mirror_bad = 1'b1;
        end
        selftest_fault = 1'b0;
        check("R2", "cache_inv after release", 64'(cache_inv), 64'd0);
        check("R3", "captured straps", 64'(strap_q), 64'(s));
        check("R9", "early release flag count", 64'(short_cnt), 64'(n_low < int'(HOLD)));
        check("R4", "busy cycles", 64'(busy_cyc), bist ? 64'(STC) : 64'd0);
        check("R4", "done pulses", 64'(done_cnt), bist ? 64'd1 : 64'd0);
        check("R5", "fetch strobes", 64'(go_cnt), park ? 64'd0 : 64'd1);
        if (!park) check("R5", "fetch address", 64'(addr_at_go), 64'(VEC));
        if (bist) check("R5", "strobe after done", 64'(t_go), 64'(t_done + 1));
        check("R6", "pass flag", 64'(selftest_pass), 64'(bist && !fault_v));
        check(park ? "R7" : "R8", "final bus_oe", 64'(bus_oe), 64'(!park));
        check("R8", "bus mirror", 64'(mirror_bad), 64'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        run_boot(30, 8'h00, 1'b1, 1'b0);
        // R9 boundary: one below and exactly at the minimum hold
        run_boot(int'(HOLD) - 1, 8'h02, 1'b1, 1'b0);
        run_boot(int'(HOLD), 8'h02, 1'b1, 1'b0);
        // R4 R6 self-test pass and fail
        run_boot(25, 8'hA4, 1'b0, 1'b0);
        run_boot(25, 8'h5A, 1'b0, 1'b1);
        // R7 park wins over an init request
        run_boot(25, 8'h81, 1'b0, 1'b0);
        run_boot(4, 8'h10, 1'b1, 1'b1);
        for (int i = 0; i < 14; i++) begin
            run_boot(4 + int'($urandom % 40), SW'($urandom), 1'($urandom), 1'($urandom));
        end
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule